// File: doc/BRIEF.md
# Pipelined Five-Lane Descending Sorter

This block accepts five unsigned words at once, together with a strobe that marks the set as valid. It returns the same five words ordered from largest to smallest, together with a matching output strobe. The sort runs as a fixed network of nine compare-exchange cells spread over six register layers.

Each layer registers all five lanes. A lane that a layer does not compare passes through a register, so every value of a set crosses the same number of flops. As a result a fresh set can enter on every clock, and each set leaves exactly six cycles after it entered. The valid strobe travels down a six-deep shift chain beside the data.

The data registers load on every cycle whether or not the strobe is high, so there is no enable fan-out on the data path. The word width is a parameter. Reset is synchronous and active high, and it clears every data and valid register to zero.

Top module: `sn5_sorter`

## Requirements
- R1: On the output, lane 0 holds the largest word and lane 4 the smallest, with each lane greater than or equal to the next lane up. Lane k occupies bits [k*WIDTH +: WIDTH] of both data ports.
- R2: The output set is a permutation of the input set that entered six cycles earlier: the same multiset of values.
- R3: `out_valid` is high exactly six clock edges after the edge that sampled `in_valid` high.
- R4: A new set may be presented on every consecutive cycle. Back-to-back sets leave in arrival order, and each is sorted independently of its neighbours.
- R5: The comparison is unsigned magnitude, so a word with its top bit set ranks above every word without it (for example F and 8 rank above 7).
- R6: While `rst` is high at a rising edge, all data and valid registers clear. From the edge after that, `out_valid` is 0 and `out_data` is all zero.
- R7: Sets with duplicated or all-equal values come out correctly ordered, with each value kept as many times as it appeared.
- R8: The data registers advance whatever the value of `in_valid`. A set held steady with `in_valid` low appears sorted on `out_data` after six edges, with `out_valid` low.
- R9: With the default 4-bit width, the input lanes 0..4 = A,5,9,4,7 (hex) produce the output lanes 0..4 = A,9,7,5,4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_data` as a set to sort |
| in_data | input | 5*WIDTH | Five unsigned words; lane k at bits [k*WIDTH +: WIDTH] |
| out_valid | output | 1 | Marks `out_data` as the result of a valid set |
| out_data | output | 5*WIDTH | Sorted words; lane 0 largest, lane 4 smallest |

## Verification
Assertions check on every cycle the properties that hold for any data:
- each compared pair leaves its layer in descending order;
- the lane sum is conserved across every layer;
- the final lanes are descending;
- `out_valid` reproduces `in_valid` from six cycles earlier;
- reset clears the outputs.

Only the bench scenarios can show that a specific set comes out as the exact permutation a software sort predicts. These scenarios cover back-to-back streams, duplicate and all-equal sets, pre-sorted and reversed sets, top-bit values, and data sent with the strobe low.

// File: rtl/sn5_pkg.sv
package sn5_pkg;
  localparam int LANES  = 5;
  localparam int LAYERS = 6;

  // Partner lane of `lane` in compare layer `layer`, or -1 when the lane passes through.
  function automatic int partner_of(input int layer, input int lane);
    int p;
    p = -1;
    case (layer)
      0: case (lane) 0: p = 1; 1: p = 0; 3: p = 4; 4: p = 3; default: p = -1; endcase
      1: case (lane) 2: p = 4; 4: p = 2; default: p = -1; endcase
      2: case (lane) 1: p = 4; 4: p = 1; 2: p = 3; 3: p = 2; default: p = -1; endcase
      3: case (lane) 0: p = 3; 3: p = 0; default: p = -1; endcase
      4: case (lane) 0: p = 2; 2: p = 0; 1: p = 3; 3: p = 1; default: p = -1; endcase
      5: case (lane) 1: p = 2; 2: p = 1; default: p = -1; endcase
      default: p = -1;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sn5_cmpx.sv
module sn5_cmpx #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  logic swap;
  // Equal words stay in place; only a strictly smaller upper word swaps.
  assign swap = (a < b);
  assign hi   = swap ? b : a;
  assign lo   = swap ? a : b;
endmodule

// File: rtl/sn5_layer.sv
module sn5_layer #(
  parameter int WIDTH = 4,
  parameter int LAYER = 0
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [sn5_pkg::LANES-1:0][WIDTH-1:0]  d_in,
  output logic [sn5_pkg::LANES-1:0][WIDTH-1:0]  d_out
);
  localparam int LANES = sn5_pkg::LANES;
  localparam int SUMW  = WIDTH + 3;

  logic [WIDTH-1:0] nxt [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int P = sn5_pkg::partner_of(LAYER, i);
    if (P < 0) begin : g_pass
      assign nxt[i] = d_in[i];
    end else if (i < P) begin : g_cmp
      sn5_cmpx #(.WIDTH(WIDTH)) u_cmpx (
        .a (d_in[i]),
        .b (d_in[P]),
        .hi(nxt[i]),
        .lo(nxt[P])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_out <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) d_out[k] <= nxt[k];
    end
  end

  function automatic logic [SUMW-1:0] lane_sum(input logic [LANES-1:0][WIDTH-1:0] v);
    logic [SUMW-1:0] s;
    s = '0;
    for (int k = 0; k < LANES; k++) s = s + SUMW'(v[k]);
    return s;
  endfunction

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R2: a layer only moves values between lanes, so their total is kept
  assert_sum_kept_R2: assert property (@(posedge clk) disable iff (rst)
    primed |-> lane_sum(d_out) == $past(lane_sum(d_in)));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    localparam int Q = sn5_pkg::partner_of(LAYER, j);
    if (Q > j) begin : g_pair
      // R1: every compared pair leaves the layer with the larger word on the lower lane
      assert_pair_order_R1: assert property (@(posedge clk) disable iff (rst)
        d_out[j] >= d_out[Q]);
    end
  end
endmodule

// File: rtl/sn5_valid_pipe.sv
module sn5_valid_pipe #(
  parameter int DEPTH = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic v_in,
  output logic v_out
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[DEPTH-2:0], v_in};
  end
  assign v_out = chain[DEPTH-1];

  logic [CW-1:0] fill;
  always_ff @(posedge clk) begin
    if (rst)                    fill <= '0;
    else if (fill != CW'(DEPTH)) fill <= fill + 1'b1;
  end

  // R3: once the chain has filled since reset, the output repeats the input DEPTH edges back
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH)) |-> v_out == $past(v_in, DEPTH));
  // R6: nothing can be valid before a set has had time to cross the chain
  assert_no_early_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (fill != CW'(DEPTH)) |-> !v_out);
endmodule

// File: rtl/sn5_sorter.sv
module sn5_sorter #(
  parameter int WIDTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [sn5_pkg::LANES*WIDTH-1:0] in_data,
  output logic                           out_valid,
  output logic [sn5_pkg::LANES*WIDTH-1:0] out_data
);
  localparam int LANES  = sn5_pkg::LANES;
  localparam int LAYERS = sn5_pkg::LAYERS;

  logic [LAYERS:0][LANES-1:0][WIDTH-1:0] stage;

  assign stage[0] = in_data;

  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    sn5_layer #(.WIDTH(WIDTH), .LAYER(l)) u_layer (
      .clk  (clk),
      .rst  (rst),
      .d_in (stage[l]),
      .d_out(stage[l+1])
    );
  end

  sn5_valid_pipe #(.DEPTH(LAYERS)) u_vpipe (
    .clk  (clk),
    .rst  (rst),
    .v_in (in_valid),
    .v_out(out_valid)
  );

  assign out_data = stage[LAYERS];

  // R6: a reset edge leaves the outputs cleared
  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  for (genvar i = 0; i + 1 < LANES; i++) begin : g_out_chk
    // R1: the final lanes are descending
    assert_out_desc_R1: assert property (@(posedge clk) disable iff (rst)
      out_data[i*WIDTH +: WIDTH] >= out_data[(i+1)*WIDTH +: WIDTH]);
  end
endmodule

// File: tb/sn5_sorter_tb.sv
module sn5_sorter_tb;
  localparam int W  = 4;
  localparam int N  = 5;
  localparam int LAT = 6;
  localparam int DW = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    logic [DW-1:0] exp;
    int            issued;
    string         tag;
  } item_t;
  item_t sb[$];

  sn5_sorter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] ref_sort(input logic [DW-1:0] v);
    logic [W-1:0] a [N];
    logic [W-1:0] t;
    logic [DW-1:0] r;
    for (int i = 0; i < N; i++) a[i] = v[i*W +: W];
    for (int i = 0; i < N; i++)
      for (int j = 0; j + 1 < N - i; j++)
        if (a[j] < a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  function automatic logic [DW-1:0] pack5(input logic [W-1:0] l0, l1, l2, l3, l4);
    return {l4, l3, l2, l1, l0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Driver: called at a falling edge, presents one valid set for one cycle
  task automatic send(input logic [DW-1:0] v, input string tag);
    item_t it;
    in_data  = v;
    in_valid = 1'b1;
    it.exp = ref_sort(v); it.issued = cyc; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 2; k++) @(negedge clk);
  endtask

  // Monitor: pops and compares every valid result
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 unexpected out_valid", out_data, '0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(out_data == it.exp, it.tag, out_data, it.exp);
          check((cyc - it.issued) == LAT, "R3 latency", DW'(cyc - it.issued), DW'(LAT));
        end
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected<20000", wd);
        finish_run();
      end
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R6 reset state", out_data, '0);
    rst = 1'b0;
    @(negedge clk);

    send(pack5(4'hA, 4'h5, 4'h9, 4'h4, 4'h7), "R9 example set");
    check(ref_sort(pack5(4'hA, 4'h5, 4'h9, 4'h4, 4'h7)) == pack5(4'hA, 4'h9, 4'h7, 4'h5, 4'h4),
          "R9 reference model", '0, '0);
    drain();

    // R4 / R1 / R2: back-to-back random stream
    for (int i = 0; i < 40; i++) send(DW'($urandom), "R4 R1 R2 random stream");
    // R7: duplicates and all-equal, back to back
    send(pack5(4'h6, 4'h6, 4'h6, 4'h6, 4'h6), "R7 all equal");
    send(pack5(4'h3, 4'hC, 4'h3, 4'hC, 4'h3), "R7 duplicates");
    send(pack5(4'h0, 4'h0, 4'hF, 4'h0, 4'h0), "R7 single distinct");
    // R1: already sorted and reversed
    send(pack5(4'hE, 4'hB, 4'h8, 4'h2, 4'h1), "R1 already sorted");
    send(pack5(4'h1, 4'h2, 4'h8, 4'hB, 4'hE), "R1 reversed");
    // R5: top bit set must rank high
    send(pack5(4'h7, 4'h8, 4'h0, 4'hF, 4'h1), "R5 unsigned compare");
    drain();

    // R4 with gaps between sets
    for (int i = 0; i < 10; i++) begin
      send(DW'($urandom), "R4 gapped stream");
      if (i % 3 == 0) @(negedge clk);
    end
    drain();

    // R8: data held with in_valid low still flows through, strobe stays low
    v = pack5(4'h2, 4'h9, 4'h4, 4'hD, 4'h0);
    in_data  = v;
    in_valid = 1'b0;
    for (int k = 0; k < LAT; k++) @(negedge clk);
    check(out_data == ref_sort(v), "R8 data without strobe", out_data, ref_sort(v));
    check(out_valid == 1'b0, "R8 strobe stays low", DW'(out_valid), '0);

    // R6: reset in the middle of a full pipeline
    for (int i = 0; i < 4; i++) send(DW'($urandom), "R6 pre-reset stream");
    rst = 1'b1;
    @(posedge clk);
    sb.delete();
    @(negedge clk);
    check(out_valid == 1'b0 && out_data == '0, "R6 mid-run reset", out_data, '0);
    rst = 1'b0;
    @(negedge clk);
    send(pack5(4'h1, 4'h3, 4'h5, 4'h7, 4'h9), "R6 after reset");
    drain();

    check(sb.size() == 0, "R3 all sets returned", DW'(sb.size()), '0);
    finish_run();
  end
endmodule